// File: doc/BRIEF.md
# Lockable Boot-Loaded Configuration Register

This block holds one 32-bit word of device configuration and fans it out as decoded control fields: pin enables, clock enables, direct-mode selects, USB trims, a watchdog sleep postscale select, and a few output enables. It takes its first value at boot. During the pre-boot window a load strobe presents a configuration word read from nonvolatile memory, together with a fail flag, a blank flag and an info-valid flag. The word is adopted only if it is trusted. Only the first strobe after reset counts.

After boot, software may rewrite the register through a plain write/read port, but only while the external 2-bit lock value is zero. Bit 7 is not stored. Writing a 1 to it fires a one-cycle pulse toward a subsystem wake input, and the bit always reads as zero. The postscale select is also given as a one-hot divide ratio.

Top module: `cfg_lock_reg`

## Requirements
- R1: After reset the read port returns 0x1F00403B, and every field output matches that value.
- R2: On the first load strobe after reset, if fail=0, blank=0 and info-valid=0, the word is adopted on the next clock edge. Every bit except 7, 4, 3, 1 and 0 takes the value of the word.
- R3: On a first strobe with any of fail, blank or info-valid at 1, the register keeps its current value.
- R4: Only the first load strobe after reset is considered. Every later strobe is ignored, trusted or not.
- R5: Bit 7 reads as 0 at all times. It is never loaded from the boot word.
- R6: Reserved bits 4, 3, 1 and 0 always read 1. Neither writes nor boot loads change them.
- R7: A bus write with lock=00 updates bits 31:8, 6, 5 and 2 on the next clock edge.
- R8: A bus write with lock 01, 10 or 11 leaves the register unchanged.
- R9: A bus write with data bit 7 set drives the wake output high for exactly one cycle, starting the cycle after the write. This happens for any lock value. A write with bit 7 clear produces no pulse.
- R10: When a bus write coincides with the first load strobe, the register follows the boot rules and the bus data is discarded.
- R11: The ratio output is one-hot with bit N set for postscale code N (bits 28:24) in the range 0..20. Codes 21..31 set bit 20.
- R12: The field outputs map to the register as follows: bit 31 CAN1 enable, 30 reference clock enable, 29 QSPI DDR clock enable, 28:24 postscale, 23:16 USB trims, 15 cache attribute, 14 reset-handling select, 13:11 serial direct enables, 10 QSPI direct enable, 9:8 comparator output enables, 6 logic-cell output enable, 5 trace enable, 2 CAN0 enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_stb | input | 1 | Pre-boot load strobe |
| boot_word | input | 32 | Configuration word from nonvolatile memory |
| boot_fail | input | 1 | Configuration-fail status |
| boot_blank | input | 1 | Blank/erased indication |
| boot_info_vld | input | 1 | Info-valid indicator (load only when 0) |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Register read value |
| lock_lvl | input | 2 | Lock field; writes allowed only at 00 |
| can1_pin_en | output | 1 | CAN1 pin enable |
| refclk_en | output | 1 | Reference clock output enable |
| qspi_ddr_clk_en | output | 1 | QSPI DDR clock enable |
| wdt_sleep_sel | output | 5 | Watchdog sleep postscale code |
| wdt_sleep_ratio | output | 21 | One-hot divide ratio, bit N = 2^N |
| usb_trim | output | 8 | Four 2-bit USB trims |
| qspi_cache_en | output | 1 | Cache attribute enable |
| rst_handling_sel | output | 1 | Reset-handling select |
| serial_direct_en | output | 3 | Serial-port direct-mode enables |
| qspi_direct_en | output | 1 | QSPI direct-mode enable |
| cmp_oe | output | 2 | Comparator output enables |
| logic_cell_oe | output | 1 | Logic-cell output enable |
| trace_en | output | 1 | Trace enable |
| can0_pin_en | output | 1 | CAN0 pin enable |
| wake_pulse | output | 1 | One-cycle subsystem wake pulse |

## Verification
The hardest case to reach is the single-use boot window. Once any strobe has landed, no stimulus from the ports can test another first strobe. The bench therefore resets before each boot scenario. It sweeps all seven untrusted flag combinations, and after each one it sends a trusted strobe to show that the window is already closed. A collision of a bus write with the first strobe is likewise set up straight after a fresh reset, in the same cycle.

// File: rtl/cfg_lock_pkg.sv
// Package: constants and the word layout of the lockable configuration register.
// Assumes a 32-bit word. Masks and bit positions are fixed by the field layout.
package cfg_lock_pkg;
    localparam int CFG_W    = 32;
    localparam int LOCK_W   = 2;
    localparam int PSC_LSB  = 24;
    localparam int PSC_W    = 5;
    localparam int PSC_MAX  = 20;
    localparam int WAKE_BIT = 7;
    localparam logic [CFG_W-1:0] CFG_RST  = 32'h1F00_403B;
    localparam logic [CFG_W-1:0] RW_MASK  = 32'hFFFF_FF64;
    localparam logic [CFG_W-1:0] RSV_MASK = 32'h0000_001B;
    localparam logic [CFG_W-1:0] RSV_VAL  = CFG_RST & RSV_MASK;

    typedef struct packed {
        logic       can1;
        logic       refclk;
        logic       ddr;
        logic [4:0] psc;
        logic [7:0] trim;
        logic       cache;
        logic       rst_sel;
        logic [2:0] ser;
        logic       qdir;
        logic [1:0] cmp;
        logic       wake;
        logic       lc;
        logic       trace;
        logic [1:0] rsv_hi;
        logic       can0;
        logic [1:0] rsv_lo;
    } cfg_word_t;
endpackage

// File: rtl/cfg_boot_gate.sv
// Boot gate: opens a single-use pre-boot window. It reports the strobe that
// falls in the window, and whether that strobe carries a trusted word.
// Assumes flags are valid in the strobe cycle.
module cfg_boot_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic boot_stb,
    input  logic boot_fail,
    input  logic boot_blank,
    input  logic boot_info_vld,
    output logic win_hit,
    output logic load_en
);
    logic done_q;

    // Mark the window as used once any strobe has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_q <= 1'b0;
        else if (boot_stb) done_q <= 1'b1;
    end

    // Qualify the window strobe with the trust flags.
    always_comb begin
        win_hit = boot_stb && !done_q;
        load_en = win_hit && !boot_fail && !boot_blank && !boot_info_vld;
    end

    p_single_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !load_en);
endmodule

// File: rtl/cfg_wake_pulse.sv
// Wake pulse generator: one registered cycle-wide pulse per triggering write.
// Assumes the trigger is already qualified by the bus write enable.
module cfg_wake_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    // Register the trigger into a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= trig;
    end

    p_lone_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> !pulse);
endmodule

// File: rtl/cfg_psc_decode.sv
// Postscale decoder: turns a code into a one-hot power-of-two ratio. Codes
// above MAX_EXP saturate to the top ratio. The clock and reset serve only the checks.
module cfg_psc_decode #(
    parameter int SEL_W   = 5,
    parameter int MAX_EXP = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel,
    output logic [MAX_EXP:0]   ratio
);
    // One comparator per ratio bit. The top bit also absorbs out-of-range codes.
    for (genvar i = 0; i <= MAX_EXP; i++) begin : g_bit
        if (i == MAX_EXP) begin : g_top
            assign ratio[i] = (32'(sel) >= MAX_EXP);
        end else begin : g_mid
            assign ratio[i] = (32'(sel) == i);
        end
    end

    p_ratio_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(ratio));
endmodule

// File: rtl/cfg_lock_reg.sv
// Top: lockable boot-loaded configuration register. It stores the writable bits,
// applies the boot-window load, gates bus writes by the lock value, and
// drives the decoded fields and the wake pulse. Assumes a single clock domain.
module cfg_lock_reg
    import cfg_lock_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  boot_stb,
    input  logic [CFG_W-1:0]      boot_word,
    input  logic                  boot_fail,
    input  logic                  boot_blank,
    input  logic                  boot_info_vld,
    input  logic                  bus_we,
    input  logic [CFG_W-1:0]      bus_wdata,
    output logic [CFG_W-1:0]      bus_rdata,
    input  logic [LOCK_W-1:0]     lock_lvl,
    output logic                  can1_pin_en,
    output logic                  refclk_en,
    output logic                  qspi_ddr_clk_en,
    output logic [PSC_W-1:0]      wdt_sleep_sel,
    output logic [PSC_MAX:0]      wdt_sleep_ratio,
    output logic [7:0]            usb_trim,
    output logic                  qspi_cache_en,
    output logic                  rst_handling_sel,
    output logic [2:0]            serial_direct_en,
    output logic                  qspi_direct_en,
    output logic [1:0]            cmp_oe,
    output logic                  logic_cell_oe,
    output logic                  trace_en,
    output logic                  can0_pin_en,
    output logic                  wake_pulse
);
    logic            win_hit;
    logic            load_en;
    logic            wr_ok;
    logic [CFG_W-1:0] cfg_q;
    cfg_word_t       f;

    cfg_boot_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .boot_stb      (boot_stb),
        .boot_fail     (boot_fail),
        .boot_blank    (boot_blank),
        .boot_info_vld (boot_info_vld),
        .win_hit       (win_hit),
        .load_en       (load_en)
    );

    // The window strobe blocks bus writes, and only lock 00 lets a write in.
    assign wr_ok = bus_we && (lock_lvl == '0) && !win_hit;

    // Register update: boot load first, then a permitted bus write. Reserved bits stay constant.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= CFG_RST;
        else if (load_en) cfg_q <= (boot_word & RW_MASK) | RSV_VAL;
        else if (wr_ok)   cfg_q <= (bus_wdata & RW_MASK) | RSV_VAL;
    end

    cfg_wake_pulse u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (bus_we && bus_wdata[WAKE_BIT]),
        .pulse (wake_pulse)
    );

    cfg_psc_decode #(.SEL_W(PSC_W), .MAX_EXP(PSC_MAX)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cfg_q[PSC_LSB +: PSC_W]),
        .ratio (wdt_sleep_ratio)
    );

    // Field fan-out from the stored word.
    always_comb begin
        f                = cfg_word_t'(cfg_q);
        bus_rdata        = cfg_q;
        can1_pin_en      = f.can1;
        refclk_en        = f.refclk;
        qspi_ddr_clk_en  = f.ddr;
        wdt_sleep_sel    = f.psc;
        usb_trim         = f.trim;
        qspi_cache_en    = f.cache;
        rst_handling_sel = f.rst_sel;
        serial_direct_en = f.ser;
        qspi_direct_en   = f.qdir;
        cmp_oe           = f.cmp;
        logic_cell_oe    = f.lc;
        trace_en         = f.trace;
        can0_pin_en      = f.can0;
    end

    p_untrusted_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && (boot_fail || boot_blank || boot_info_vld)) |=> $stable(bus_rdata));
    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && lock_lvl != 2'b00 && !boot_stb) |=> $stable(bus_rdata));
    p_boot_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> bus_rdata[31:8] == $past(boot_word[31:8]));
    p_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[WAKE_BIT] == 1'b0);
    p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & RSV_MASK) == RSV_VAL);
    p_wake_any_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata[WAKE_BIT]) |=> wake_pulse);
endmodule

// File: tb/cfg_lock_reg_bench.sv
// Bench: directed sweeps over the boot flags, the bit positions, the postscale codes and the lock values.
module cfg_lock_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_stb = 1'b0;
    logic [31:0] boot_word = '0;
    logic        boot_fail = 1'b0, boot_blank = 1'b0, boot_info_vld = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  lock_lvl = 2'b00;
    logic        can1_pin_en, refclk_en, qspi_ddr_clk_en;
    logic [4:0]  wdt_sleep_sel;
    logic [20:0] wdt_sleep_ratio;
    logic [7:0]  usb_trim;
    logic        qspi_cache_en, rst_handling_sel;
    logic [2:0]  serial_direct_en;
    logic        qspi_direct_en;
    logic [1:0]  cmp_oe;
    logic        logic_cell_oe, trace_en, can0_pin_en, wake_pulse;

    int total = 0;
    int bad = 0;
    logic wake_seen;
    logic [31:0] exp_q;

    localparam logic [31:0] RST_V = 32'h1F00_403B;
    localparam logic [31:0] WMASK = 32'hFFFF_FF64;
    localparam logic [31:0] RSV   = 32'h0000_001B;

    always #10 clk = ~clk;

    cfg_lock_reg u_cfg_lock_reg (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fields();
        return {can1_pin_en, refclk_en, qspi_ddr_clk_en, wdt_sleep_sel, usb_trim,
                qspi_cache_en, rst_handling_sel, serial_direct_en, qspi_direct_en,
                cmp_oe, 1'b0, logic_cell_oe, trace_en, 2'b00, can0_pin_en, 2'b00};
    endfunction

    function automatic logic [20:0] ratio_of(input int n);
        return (n > 20) ? (21'd1 << 20) : (21'd1 << n);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic boot(input logic [31:0] w, input logic fl, input logic bl, input logic iv);
        @(negedge clk);
        boot_stb = 1'b1; boot_word = w; boot_fail = fl; boot_blank = bl; boot_info_vld = iv;
        @(posedge clk); #1;
        @(negedge clk); boot_stb = 1'b0; boot_fail = 1'b0; boot_blank = 1'b0; boot_info_vld = 1'b0;
    endtask

    task automatic bus_wr(input logic [31:0] d, input logic [1:0] lk);
        @(negedge clk); bus_we = 1'b1; bus_wdata = d; lock_lvl = lk;
        @(posedge clk); #1; wake_seen = wake_pulse;
        @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
    endtask

    initial begin
        #(20 * 100000);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset value and R12 field map, R11 saturated code 31
        chk("R1", bus_rdata, RST_V);
        chk("R12", fields(), RST_V & WMASK);
        chk("R11", 32'(wdt_sleep_ratio), 32'(ratio_of(31)));
        chk("R9", 32'(wake_pulse), 32'd0);

        // R3 all untrusted flag combinations, then R4 a late trusted strobe
        for (int c = 1; c < 8; c++) begin
            do_reset();
            boot(32'hA5A5_A5A5, c[0], c[1], c[2]);
            chk("R3", bus_rdata, RST_V);
            boot(32'h5A5A_5A5A, 1'b0, 1'b0, 1'b0);
            chk("R4", bus_rdata, RST_V);
        end

        // R2 trusted load, R5 bit 7 never loaded, R6 reserved kept
        do_reset();
        boot(32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        chk("R2", bus_rdata, 32'hFFFF_FF7F);
        chk("R5", 32'(bus_rdata[7]), 32'd0);
        chk("R12", fields(), 32'hFFFF_FFFF & WMASK);
        boot(32'h0000_0000, 1'b0, 1'b0, 1'b0);
        chk("R4", bus_rdata, 32'hFFFF_FF7F);

        // R7 walking-one writes, R5/R6 readback, R9 pulse on bit 7
        for (int i = 0; i < 32; i++) begin
            logic [31:0] d;
            d = 32'd1 << i;
            bus_wr(d, 2'b00);
            exp_q = (d & WMASK) | RSV;
            chk("R7", bus_rdata, exp_q);
            chk("R12", fields(), d & WMASK);
            chk("R9", 32'(wake_seen), 32'(i == 7));
            @(posedge clk); #1;
            chk("R9", 32'(wake_pulse), 32'd0);
        end

        // R11 every postscale code
        for (int n = 0; n < 32; n++) begin
            bus_wr(32'(n) << 24, 2'b00);
            chk("R11", 32'(wdt_sleep_ratio), 32'(ratio_of(n)));
            chk("R11", 32'(wdt_sleep_sel), 32'(n));
        end

        // R8 writes blocked by each nonzero lock; R9 pulse still fires
        bus_wr(32'h1234_5678, 2'b00);
        exp_q = (32'h1234_5678 & WMASK) | RSV;
        chk("R7", bus_rdata, exp_q);
        for (int lk = 1; lk < 4; lk++) begin
            bus_wr(32'hEDCB_A987, 2'(lk));
            chk("R8", bus_rdata, exp_q);
            chk("R9", 32'(wake_seen), 32'd1);
            @(posedge clk); #1;
            chk("R9", 32'(wake_pulse), 32'd0);
            bus_wr(32'h0000_0000, 2'(lk));
            chk("R8", bus_rdata, exp_q);
            chk("R9", 32'(wake_seen), 32'd0);
        end

        // R10 bus write colliding with the first trusted strobe
        do_reset();
        @(negedge clk);
        boot_stb = 1'b1; boot_word = 32'hC3C3_3C3C;
        bus_we = 1'b1; bus_wdata = 32'h0F0F_F0F0; lock_lvl = 2'b00;
        @(posedge clk); #1;
        @(negedge clk); boot_stb = 1'b0; bus_we = 1'b0;
        chk("R10", bus_rdata, (32'hC3C3_3C3C & WMASK) | RSV);
        // R10 collision with an untrusted strobe also drops the bus data
        do_reset();
        @(negedge clk);
        boot_stb = 1'b1; boot_word = 32'hC3C3_3C3C; boot_blank = 1'b1;
        bus_we = 1'b1; bus_wdata = 32'h0F0F_F0F0;
        @(posedge clk); #1;
        @(negedge clk); boot_stb = 1'b0; bus_we = 1'b0; boot_blank = 1'b0;
        chk("R10", bus_rdata, RST_V);
        bus_wr(32'h0F0F_F0F0, 2'b00);
        chk("R7", bus_rdata, (32'h0F0F_F0F0 & WMASK) | RSV);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule